// File: doc/BRIEF.md
# UART Receive Channel Status Controller

This block is the software-facing receive side of one asynchronous serial channel. A bit-level receiver outside this block reports each completed frame as a one-cycle event carrying the byte and two quality bits: a parity mismatch and a bad stop bit. The block stores the byte in a data register and raises a buffer-full flag. It keeps three sticky error flags, for parity, framing and overrun. It also holds a channel-enable status bit.

Software reaches everything through a simple synchronous register bus. Reading the data register frees the buffer. Error flags are removed only by writing ones to a clear-trigger register, so software can write back the status word it just read. The channel is switched on and off through two write-only trigger registers. A read-only status bit reflects the result. Parity and overrun faults are recovered by reading the data and clearing the flags. A framing fault also needs a stop and restart of the channel, so that it can lock onto the next start bit.

Register map (word addresses on `bus_addr`): 0 receive data (read), 1 status (read: bit0 buffer full, bit1 parity error, bit2 framing error, bit3 overrun error), 2 flag clear (write-1, bits 1..3 match the status bits), 3 start trigger (write bit0), 4 stop trigger (write bit0), 5 enable status (read bit0). A read of any other address returns 0. When no read is in progress, `bus_rdata` is 0.

Top module: `uart_rx_status_ctrl`

## Requirements
- R1: After reset the channel is disabled, every status flag is 0 and the receive data register reads 0.
- R2: A receive event while enabled stores the byte in the data register (address 0) and sets buffer full (status bit0).
- R3: A read of address 0 clears buffer full after that cycle. If a new byte arrives in the same cycle as the read, buffer full stays set and no overrun is flagged.
- R4: A byte arriving while buffer full is set, with no data read in that cycle, sets the overrun flag (status bit3) and replaces the stored byte.
- R5: A byte with bad parity sets status bit1, and a byte with a bad stop bit sets status bit2. In both cases the byte is still stored and buffer full is still set.
- R6: Writing the flag-clear register clears each error flag whose matching bit (1, 2 or 3) is written as 1. Bits written as 0, and bit0, change nothing.
- R7: When an error event and a clear of the same flag fall in the same cycle, the flag ends set.
- R8: Writing 1 to bit0 of address 4 clears the enable status, and writing 1 to bit0 of address 3 sets it. The enable status is visible at address 5 bit0 and on `chan_en` from the next cycle.
- R9: Receive events while the channel is disabled change neither the data register nor any flag.
- R10: The flag-clear, start and stop registers read as 0, and writing 0 to start or stop bit0 has no effect.
- R11: After a framing error, the sequence data read, status read, write-back of the status value to flag clear, stop, start leaves all flags at 0, and the next byte is received cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, valid in the access cycle |
| rx_valid | input | 1 | One-cycle frame-complete event from the receiver |
| rx_byte | input | DATA_W | Received byte |
| rx_parity_bad | input | 1 | Frame had a parity mismatch, qualified by rx_valid |
| rx_stop_bad | input | 1 | Frame had a bad stop bit, qualified by rx_valid |
| chan_en | output | 1 | Channel enable status |
| buf_full | output | 1 | Buffer-full flag |

## Verification
The bench targets the same-cycle collisions. These are a data read meeting a new byte, where a wrong design would flag a false overrun or drop buffer full. They also include a flag clear meeting a fresh error, where a design that lets the clear win would lose the fault. Disabled-channel traffic is sent so that a design gating on the wrong enable would alter data or flags. Writes of 0 and of bit0 to the trigger registers catch a design that toggles or clears on any write. The full framing-recovery sequence checks that the stop and restart leaves the channel clean for the next byte.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

  localparam int ADDR_W  = 3;
  localparam int NUM_ERR = 3;

  // status bit positions; flag-clear bits line up with these
  localparam int ST_FULL = 0;
  localparam int ST_PAR  = 1;
  localparam int ST_FRM  = 2;
  localparam int ST_OVR  = 3;
  localparam int ST_W    = 4;

  // error vector index
  localparam int E_PAR = 0;
  localparam int E_FRM = 1;
  localparam int E_OVR = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 3'd0,
    A_STAT  = 3'd1,
    A_FCLR  = 3'd2,
    A_START = 3'd3,
    A_STOP  = 3'd4,
    A_ENSTS = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic rd_data;
    logic rd_stat;
    logic rd_ensts;
    logic wr_fclr;
    logic wr_start;
    logic wr_stop;
  } bus_strb_t;

endpackage

// File: rtl/uart_rxs_rst_sync.sv
module uart_rxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/uart_rxs_bus_dec.sv
module uart_rxs_bus_dec
  import uart_rxs_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output bus_strb_t         strb
);

  logic rd_acc;
  logic wr_acc;

  always_comb begin
    rd_acc        = bus_sel & ~bus_wr;
    wr_acc        = bus_sel &  bus_wr;
    strb.rd_data  = rd_acc & (bus_addr == A_DATA);
    strb.rd_stat  = rd_acc & (bus_addr == A_STAT);
    strb.rd_ensts = rd_acc & (bus_addr == A_ENSTS);
    strb.wr_fclr  = wr_acc & (bus_addr == A_FCLR);
    strb.wr_start = wr_acc & (bus_addr == A_START);
    strb.wr_stop  = wr_acc & (bus_addr == A_STOP);
  end

endmodule

// File: rtl/uart_rxs_enable.sv
module uart_rxs_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic start_hit,
  input  logic stop_hit,
  output logic en_q
);

  logic en_d;
  logic en_we;

  always_comb begin
    en_we = start_hit | stop_hit;
    en_d  = en_q;
    if (stop_hit)       en_d = 1'b0;
    else if (start_hit) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_we) en_q <= en_d;
  end

endmodule

// File: rtl/uart_rxs_flags.sv
module uart_rxs_flags
  import uart_rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en,
  input  logic               rx_valid,
  input  logic [DATA_W-1:0]  rx_byte,
  input  logic               rx_parity_bad,
  input  logic               rx_stop_bad,
  input  logic               data_rd,
  input  logic [NUM_ERR-1:0] clr_mask,
  output logic [DATA_W-1:0]  data_q,
  output logic               full_q,
  output logic [NUM_ERR-1:0] err_q
);

  logic               accept;
  logic [NUM_ERR-1:0] err_set;
  logic [NUM_ERR-1:0] err_d;
  logic               full_d;
  logic               full_we;

  always_comb begin
    accept         = chan_en & rx_valid;
    err_set[E_PAR] = accept & rx_parity_bad;
    err_set[E_FRM] = accept & rx_stop_bad;
    err_set[E_OVR] = accept & full_q & ~data_rd;
    full_we        = accept | data_rd;
    full_d         = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (accept)  data_q <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       full_q <= 1'b0;
    else if (full_we) full_q <= full_d;
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    logic we;
    always_comb begin
      we       = err_set[i] | clr_mask[i];
      err_d[i] = err_set[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  err_q[i] <= 1'b0;
      else if (we) err_q[i] <= err_d[i];
    end
  end

endmodule

// File: rtl/uart_rx_status_ctrl.sv
module uart_rx_status_ctrl
  import uart_rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_parity_bad,
  input  logic              rx_stop_bad,
  output logic              chan_en,
  output logic              buf_full
);

  localparam int PAD_W = DATA_W - ST_W;

  logic               rst_sync_n;
  bus_strb_t          strb;
  logic               start_hit;
  logic               stop_hit;
  logic [NUM_ERR-1:0] clr_mask;
  logic [DATA_W-1:0]  rx_data;
  logic [NUM_ERR-1:0] err_flags;
  logic [ST_W-1:0]    stat_word;

  uart_rxs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  uart_rxs_bus_dec u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .strb     (strb)
  );

  always_comb begin
    start_hit = strb.wr_start & bus_wdata[0];
    stop_hit  = strb.wr_stop  & bus_wdata[0];
    clr_mask  = strb.wr_fclr ? bus_wdata[ST_OVR:ST_PAR] : '0;
  end

  uart_rxs_enable u_en (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_hit (start_hit),
    .stop_hit  (stop_hit),
    .en_q      (chan_en)
  );

  uart_rxs_flags #(.DATA_W(DATA_W)) u_flags (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .chan_en       (chan_en),
    .rx_valid      (rx_valid),
    .rx_byte       (rx_byte),
    .rx_parity_bad (rx_parity_bad),
    .rx_stop_bad   (rx_stop_bad),
    .data_rd       (strb.rd_data),
    .clr_mask      (clr_mask),
    .data_q        (rx_data),
    .full_q        (buf_full),
    .err_q         (err_flags)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[ST_FULL] = buf_full;
    stat_word[ST_PAR]  = err_flags[E_PAR];
    stat_word[ST_FRM]  = err_flags[E_FRM];
    stat_word[ST_OVR]  = err_flags[E_OVR];
    bus_rdata = '0;
    if (strb.rd_data)       bus_rdata = rx_data;
    else if (strb.rd_stat)  bus_rdata = {{PAD_W{1'b0}}, stat_word};
    else if (strb.rd_ensts) bus_rdata = {{(DATA_W-1){1'b0}}, chan_en};
  end

endmodule

// File: rtl/uart_rxs_chk.sv
module uart_rxs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_parity_bad,
  input logic              rx_stop_bad,
  input logic              data_rd,
  input logic              start_hit,
  input logic              stop_hit,
  input logic              chan_en,
  input logic              buf_full,
  input logic [DATA_W-1:0] rx_data,
  input logic [2:0]        err_flags
);

  // R4
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && rx_valid && buf_full && !data_rd) |=> err_flags[2]);

  // R3
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !(chan_en && rx_valid)) |=> !buf_full);

  // R3
  read_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && chan_en && rx_valid && !err_flags[2]) |=> (buf_full && !err_flags[2]));

  // R9
  ignore_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !data_rd) |=> ($stable(rx_data) && $stable(buf_full)));

  // R8
  stop_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !chan_en);

  // R8
  start_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hit && !stop_hit) |=> chan_en);

  // R7
  par_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && rx_valid && rx_parity_bad) |=> err_flags[0]);

  // R7
  frm_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && rx_valid && rx_stop_bad) |=> err_flags[1]);

  // R2
  byte_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && rx_valid) |=> buf_full);

endmodule

bind uart_rx_status_ctrl uart_rxs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .rx_valid      (rx_valid),
  .rx_parity_bad (rx_parity_bad),
  .rx_stop_bad   (rx_stop_bad),
  .data_rd       (strb.rd_data),
  .start_hit     (start_hit),
  .stop_hit      (stop_hit),
  .chan_en       (chan_en),
  .buf_full      (buf_full),
  .rx_data       (rx_data),
  .err_flags     (err_flags)
);

// File: tb/uart_rx_status_ctrl_tb.sv
module uart_rx_status_ctrl_tb;

  logic       clk;
  logic       rst_n;
  logic       bus_sel;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       rx_parity_bad;
  logic       rx_stop_bad;
  logic       chan_en;
  logic       buf_full;

  uart_rx_status_ctrl #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_parity_bad(rx_parity_bad),
    .rx_stop_bad(rx_stop_bad), .chan_en(chan_en), .buf_full(buf_full)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  // behavioural reference state
  int m_en, m_full, m_par, m_frm, m_ovr, m_data;

  function automatic int exp_rdata(bit s, bit w, int a);
    if (!(s && !w)) return 0;
    case (a)
      0: return m_data;
      1: return m_full + 2*m_par + 4*m_frm + 8*m_ovr;
      5: return m_en;
      default: return 0;
    endcase
  endfunction

  task automatic check(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic model_update(bit s, bit w, int a, int d, bit v, int b, bit p, bit f);
    bit acc, rdd;
    int clrm;
    int np, nf, no, nfull, ndata, nen;
    acc   = (m_en != 0) && v;
    rdd   = s && !w && (a == 0);
    clrm  = (s && w && a == 2) ? ((d >> 1) & 7) : 0;
    np    = (acc && p) ? 1 : (m_par && !(clrm & 1));
    nf    = (acc && f) ? 1 : (m_frm && !(clrm & 2));
    no    = (acc && m_full && !rdd) ? 1 : (m_ovr && !(clrm & 4));
    nfull = acc ? 1 : (m_full && !rdd);
    ndata = acc ? b : m_data;
    nen   = m_en;
    if (s && w && a == 3 && (d & 1)) nen = 1;
    if (s && w && a == 4 && (d & 1)) nen = 0;
    m_par = np; m_frm = nf; m_ovr = no; m_full = nfull; m_data = ndata; m_en = nen;
  endtask

  task automatic step(bit s, bit w, int a, int d, bit v, int b, bit p, bit f);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a[2:0]; bus_wdata = d[7:0];
    rx_valid = v; rx_byte = b[7:0]; rx_parity_bad = p; rx_stop_bad = f;
    #4;
    check("rdata", int'(bus_rdata), exp_rdata(s, w, a));
    check("chan_en", int'(chan_en), m_en);
    check("buf_full", int'(buf_full), m_full);
    @(posedge clk);
    #1;
    model_update(s, w, a, d, v, b, p, f);
  endtask

  task automatic idle();                   step(0,0,0,0,0,0,0,0); endtask
  task automatic rd(int a);                step(1,0,a,0,0,0,0,0); endtask
  task automatic wr(int a, int d);         step(1,1,a,d,0,0,0,0); endtask
  task automatic rx(int b, bit p, bit f);  step(0,0,0,0,1,b,p,f); endtask

  task automatic expect_reg(int a, int exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a[2:0]; bus_wdata = 0;
    rx_valid = 0; rx_byte = 0; rx_parity_bad = 0; rx_stop_bad = 0;
    #4;
    check($sformatf("reg%0d direct", a), int'(bus_rdata), exp);
    @(posedge clk);
    #1;
    model_update(1, 0, a, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    m_en = 0; m_full = 0; m_par = 0; m_frm = 0; m_ovr = 0; m_data = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_byte = 0; rx_parity_bad = 0; rx_stop_bad = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    cur_req = "R1";
    for (int a = 0; a < 8; a++) expect_reg(a, 0);

    cur_req = "R9";
    rx(8'hC3, 1, 1);
    expect_reg(0, 0);
    expect_reg(1, 0);

    cur_req = "R10";
    wr(3, 0);
    expect_reg(5, 0);
    rd(2); rd(3); rd(4);
    expect_reg(2, 0);
    expect_reg(3, 0);

    cur_req = "R8";
    wr(3, 1);
    expect_reg(5, 1);
    cur_req = "R10";
    wr(4, 8'hFE);
    expect_reg(5, 1);

    cur_req = "R2";
    rx(8'hA5, 0, 0);
    expect_reg(1, 8'h01);
    cur_req = "R3";
    expect_reg(0, 8'hA5);
    expect_reg(1, 8'h00);

    cur_req = "R4";
    rx(8'h11, 0, 0);
    rx(8'h22, 0, 0);
    expect_reg(1, 8'h09);

    cur_req = "R6";
    wr(2, 0);
    expect_reg(1, 8'h09);
    wr(2, 8'h01);
    expect_reg(1, 8'h09);
    wr(2, 8'h08);
    expect_reg(1, 8'h01);

    cur_req = "R3";
    step(1, 0, 0, 0, 1, 8'h33, 0, 0);
    expect_reg(1, 8'h01);
    expect_reg(0, 8'h33);

    cur_req = "R5";
    rx(8'h5A, 1, 0);
    expect_reg(1, 8'h03);
    expect_reg(0, 8'h5A);
    wr(2, 8'h02);
    expect_reg(1, 8'h00);

    cur_req = "R7";
    step(1, 1, 2, 8'h02, 1, 8'h44, 1, 0);
    expect_reg(1, 8'h03);
    step(1, 1, 2, 8'h0E, 1, 8'h55, 0, 1);
    expect_reg(1, 8'h0D);
    rd(0);
    wr(2, 8'h0E);
    expect_reg(1, 8'h00);

    cur_req = "R11";
    rx(8'h7E, 0, 1);
    expect_reg(0, 8'h7E);
    expect_reg(1, 8'h04);
    wr(2, 8'h04);
    wr(4, 1);
    expect_reg(5, 0);
    cur_req = "R9";
    rx(8'h99, 1, 1);
    expect_reg(1, 8'h00);
    expect_reg(0, 8'h7E);
    cur_req = "R11";
    wr(3, 1);
    rx(8'h3C, 0, 0);
    expect_reg(1, 8'h01);
    expect_reg(0, 8'h3C);

    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int kind;
      kind = $urandom_range(0, 9);
      case (kind)
        0, 1, 2: rx($urandom_range(0, 255), ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
        3:       rd($urandom_range(0, 7));
        4:       rd(0);
        5:       wr(2, $urandom_range(0, 255));
        6:       wr(($urandom_range(0, 7) == 0) ? 4 : 3, $urandom_range(0, 1));
        7:       step(1, 0, 0, 0, 1, $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 1));
        8:       step(1, 1, 2, $urandom_range(0, 15), 1, $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 1));
        default: idle();
      endcase
    end
    idle();
    finish_run();
  end

endmodule